// File: doc/BRIEF.md
# Gated 13/16-Bit Counter-Timer

A counter-timer whose count lives in two byte registers, a high byte and a low byte. In the narrow mode it counts through 13 bits: the high byte and the five low bits of the low byte. In the wide mode it counts through all 16 bits. Each increment comes from one of three sources. The first is a falling edge on an asynchronous count pin. The second is every system clock. The third is each cycle on which an externally generated prescaled tick is high.

Counting runs only while a run bit is set. An optional gate can also hold it: an asynchronous gate pin, whose active level is chosen by an XOR polarity bit. When the count wraps to zero, a sticky overflow flag is set. The interrupt request is that flag qualified by an enable bit. Software loads and inspects the count bytes and the control byte through a byte-wide write port and a combinational read port.

Top module: `gated_timer`

## Requirements
- R1: After reset, the low byte, the high byte and the control byte (address 2) read 0x00, and irq_o is 0.
- R2: With control bit 5 (wide) at 0, the count is {high, low[4:0]}. It steps from 0x1FFF to 0x0000, and that wrap sets the overflow flag (control bit 7). Bits 7:5 of the low byte read as zero and do not change.
- R3: With wide at 1, the count is {high, low} across 16 bits. It steps from 0xFFFF to 0x0000, and that wrap sets the overflow flag.
- R4: With control bit 3 (pin mode) at 1, each high-to-low transition of cnt_pin_i gives exactly one increment. The pin passes through a two-flop synchronizer, so the new count reads back after the third rising clock edge that samples the low level.
- R5: With pin mode at 0 and control bit 4 (fast) at 1, the count increments on every clock.
- R6: With pin mode at 0 and fast at 0, the count increments on each clock where tick_i is 1.
- R7: While control bit 0 (run) is 0, the count holds. Setting run does not clear or reload the count.
- R8: With control bit 1 (gate enable) at 1, counting happens only while the synchronized gate_pin_i XOR control bit 2 (polarity) is 1. The synchronizer is two flops.
- R9: irq_o is 1 exactly when the overflow flag and control bit 6 (interrupt enable) are both 1.
- R10: A control write with bit 7 at 0 clears the overflow flag, and a control write with bit 7 at 1 leaves it unchanged. A wrap in the same cycle as a clearing write leaves the flag set.
- R11: A write to the low byte (address 0) or the high byte (address 1) takes effect in full and cancels any increment in that cycle. Writes to address 3 are ignored.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| tick_i | input | 1 | Prescaled tick, synchronous to clk |
| cnt_pin_i | input | 1 | Asynchronous external count pin |
| gate_pin_i | input | 1 | Asynchronous external gate pin |
| wr_en_i | input | 1 | Register write strobe |
| wr_addr_i | input | 2 | Write address: 0 low, 1 high, 2 control |
| wr_data_i | input | 8 | Write data |
| rd_addr_i | input | 2 | Read address, same map as writes |
| rd_data_o | output | 8 | Combinational read data |
| irq_o | output | 1 | Interrupt request |

## Verification
Most internal faults corrupt the count, and a corrupted count shows on the read port one clock after the bad edge. The exception is a fault in the synchronizer or in edge detection. That fault shifts or duplicates increments, and it shows two to three clocks after a pin or gate change. A bad overflow flag appears on irq_o, and on control bit 7, on the clock right after the wrap. The bench's reference model reads all three addresses and irq_o on every cycle, so any divergence is flagged within the cycle it becomes visible.

// File: rtl/gated_timer.sv
module gated_timer (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       tick_i,
  input  logic       cnt_pin_i,
  input  logic       gate_pin_i,
  input  logic       wr_en_i,
  input  logic [1:0] wr_addr_i,
  input  logic [7:0] wr_data_i,
  input  logic [1:0] rd_addr_i,
  output logic [7:0] rd_data_o,
  output logic       irq_o
);
  logic [7:0]  lo_q, hi_q;
  logic [6:0]  ctl_q;
  logic        ovf_q;
  logic [2:0]  pin_sr;
  logic [1:0]  gate_sr;
  logic [13:0] sum13;
  logic [16:0] sum16;
  logic        wr_lo, wr_hi, wr_ctl, fall, gate_ok, pulse, step, wrap;

  wire run  = ctl_q[0];
  wire gen  = ctl_q[1];
  wire pol  = ctl_q[2];
  wire pinm = ctl_q[3];
  wire fast = ctl_q[4];
  wire wide = ctl_q[5];
  wire ien  = ctl_q[6];

  assign wr_lo   = wr_en_i && wr_addr_i == 2'd0;
  assign wr_hi   = wr_en_i && wr_addr_i == 2'd1;
  assign wr_ctl  = wr_en_i && wr_addr_i == 2'd2;
  assign fall    = pin_sr[2] & ~pin_sr[1];
  assign gate_ok = ~gen | (gate_sr[1] ^ pol);
  assign pulse   = pinm ? fall : (fast | tick_i);
  assign step    = run & gate_ok & pulse & ~wr_lo & ~wr_hi;
  assign sum13   = {1'b0, hi_q, lo_q[4:0]} + 14'd1;
  assign sum16   = {1'b0, hi_q, lo_q} + 17'd1;
  assign wrap    = step & (wide ? sum16[16] : sum13[13]);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      pin_sr  <= '0;
      gate_sr <= '0;
    end else begin
      pin_sr  <= {pin_sr[1:0], cnt_pin_i};
      gate_sr <= {gate_sr[0], gate_pin_i};
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      lo_q  <= '0;
      hi_q  <= '0;
      ctl_q <= '0;
      ovf_q <= 1'b0;
    end else begin
      if (step) begin
        if (wide) {hi_q, lo_q} <= sum16[15:0];
        else      {hi_q, lo_q[4:0]} <= sum13[12:0];
      end
      if (wr_lo) lo_q <= wr_data_i;
      if (wr_hi) hi_q <= wr_data_i;
      if (wr_ctl) begin
        ctl_q <= wr_data_i[6:0];
        ovf_q <= (ovf_q & wr_data_i[7]) | wrap;
      end else begin
        ovf_q <= ovf_q | wrap;
      end
    end
  end

  always_comb begin
    case (rd_addr_i)
      2'd0:    rd_data_o = wide ? lo_q : {3'b000, lo_q[4:0]};
      2'd1:    rd_data_o = hi_q;
      2'd2:    rd_data_o = {ovf_q, ctl_q};
      default: rd_data_o = 8'h00;
    endcase
  end

  assign irq_o = ovf_q & ien;

  AST_RUN_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    (!run && !wr_lo && !wr_hi) |=> $stable({hi_q, lo_q})); // R7
  AST_WRITE_WINS: assert property (@(posedge clk) disable iff (!rst_n)
    wr_lo |=> lo_q == $past(wr_data_i)); // R11
  AST_WRAP_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(ovf_q) |-> ($past(wide) ? ({hi_q, lo_q} == 16'h0) : ({hi_q, lo_q[4:0]} == 13'h0))); // R3
  AST_UPPER_FROZEN: assert property (@(posedge clk) disable iff (!rst_n)
    (!wide && !wr_lo) |=> lo_q[7:5] == $past(lo_q[7:5])); // R2
  AST_OVF_STICKY: assert property (@(posedge clk) disable iff (!rst_n)
    (ovf_q && !(wr_ctl && !wr_data_i[7])) |=> ovf_q); // R10
endmodule

// File: tb/tb_gated_timer.sv
`timescale 1ns/100ps
module tb_gated_timer;
  logic clk = 0, rst_n = 0, tick_i = 0, cnt_pin_i = 1, gate_pin_i = 0;
  logic wr_en_i = 0;
  logic [1:0] wr_addr_i = 0, rd_addr_i = 0;
  logic [7:0] wr_data_i = 0, rd_data_o;
  logic irq_o;
  int errors = 0, checks = 0;
  string phase = "R1";
  bit done = 0;

  gated_timer dut (.*);

  always #2 clk = ~clk;

  int m_lo = 0, m_hi = 0, m_ctl = 0, m_ovf = 0;
  int p1 = 0, p2 = 0, p3 = 0, g1 = 0, g2 = 0;

  always @(posedge clk) begin
    if (!rst_n) begin
      m_lo = 0; m_hi = 0; m_ctl = 0; m_ovf = 0;
      p1 = 0; p2 = 0; p3 = 0; g1 = 0; g2 = 0;
    end else begin
      int cnt, lim, en, pls, inc, wrp, cw;
      en  = (m_ctl & 1) && (!(m_ctl & 2) || (g2 ^ ((m_ctl >> 2) & 1)));
      if (m_ctl & 8) pls = p3 && !p2;
      else           pls = (m_ctl & 16) ? 1 : tick_i;
      cw  = wr_en_i && wr_addr_i < 2;
      inc = en && pls && !cw;
      wrp = 0;
      if (inc) begin
        if (m_ctl & 32) begin
          cnt = m_hi * 256 + m_lo + 1; lim = 65536;
          if (cnt == lim) begin cnt = 0; wrp = 1; end
          m_hi = cnt / 256; m_lo = cnt % 256;
        end else begin
          cnt = m_hi * 32 + (m_lo % 32) + 1; lim = 8192;
          if (cnt == lim) begin cnt = 0; wrp = 1; end
          m_hi = cnt / 32; m_lo = (m_lo / 32) * 32 + cnt % 32;
        end
      end
      if (wr_en_i && wr_addr_i == 0) m_lo = wr_data_i;
      if (wr_en_i && wr_addr_i == 1) m_hi = wr_data_i;
      if (wr_en_i && wr_addr_i == 2) begin
        m_ctl = wr_data_i % 128;
        m_ovf = (m_ovf && wr_data_i[7]) || wrp;
      end else m_ovf = m_ovf || wrp;
      p3 = p2; p2 = p1; p1 = cnt_pin_i;
      g2 = g1; g1 = gate_pin_i;
    end
  end

  always @(negedge clk) begin
    if (!done) begin
      for (int a = 0; a < 3; a++) begin
        int exp;
        rd_addr_i = a[1:0];
        #0.2;
        if (a == 0) exp = (m_ctl & 32) ? m_lo : m_lo % 32;
        else if (a == 1) exp = m_hi;
        else exp = m_ovf * 128 + m_ctl;
        checks++;
        if (rd_data_o !== exp[7:0]) begin
          errors++;
          $display("FAIL %s addr%0d: actual %02h expected %02h", phase, a, rd_data_o, exp[7:0]);
        end
      end
      checks++;
      if (irq_o !== (m_ovf && (m_ctl & 64) != 0)) begin // R9
        errors++;
        $display("FAIL %s irq: actual %0b expected %0b", phase, irq_o, m_ovf && (m_ctl & 64) != 0);
      end
    end
  end

  task automatic step_to_drive();
    @(negedge clk); #1;
  endtask

  task automatic wr(input logic [1:0] a, input logic [7:0] d);
    step_to_drive();
    wr_en_i = 1; wr_addr_i = a; wr_data_i = d;
    step_to_drive();
    wr_en_i = 0;
  endtask

  task automatic idle(input int n);
    repeat (n) step_to_drive();
  endtask

  initial begin
    #(40000 * 4);
    errors++; checks++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    idle(3);
    rst_n = 1;
    phase = "R1"; idle(3);
    phase = "R3"; wr(0, 8'hFC); wr(1, 8'hFF); wr(2, 8'h71); idle(8);
    phase = "R9"; idle(2);
    phase = "R10"; wr(2, 8'hF1); idle(2); wr(2, 8'h71); idle(2); wr(2, 8'h00); idle(2);
    phase = "R2"; wr(0, 8'hFE); wr(1, 8'hFF); wr(2, 8'h51); idle(6); wr(2, 8'h00);
    phase = "R5"; wr(2, 8'h31); idle(5);
    phase = "R6"; wr(2, 8'h01);
    for (int i = 0; i < 40; i++) begin step_to_drive(); tick_i = $urandom_range(0, 1); end
    step_to_drive(); tick_i = 0;
    phase = "R4"; wr(2, 8'h09);
    for (int k = 0; k < 12; k++) begin
      cnt_pin_i = 0; idle(k % 4 + 1);
      cnt_pin_i = 1; idle(k % 3 + 1);
    end
    idle(4);
    phase = "R8"; wr(2, 8'h13);
    for (int k = 0; k < 10; k++) begin gate_pin_i = ~gate_pin_i; idle(k % 3 + 1); end
    wr(2, 8'h17);
    for (int k = 0; k < 10; k++) begin gate_pin_i = ~gate_pin_i; idle(k % 4 + 1); end
    phase = "R7"; wr(2, 8'h10); idle(5); wr(2, 8'h11); idle(3);
    phase = "R11"; wr(0, 8'h33); wr(1, 8'h44); wr(3, 8'hAA); idle(3);
    phase = "R10"; wr(2, 8'h71); wr(0, 8'hFF); wr(1, 8'hFF); wr(2, 8'h71); idle(3);
    wr(2, 8'h00); idle(3);
    done = 1;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule